// File: doc/BRIEF.md
# Region Address Decoder with Built-in Error Responder

This block sits between the bus master side and a set of AHB slaves. It matches the address phase of each transfer against a parameter table of memory regions, each a whole number of 1 KB blocks starting on a 1 KB boundary. From that match it drives one select line per slave. Addresses that fall outside every region have no slave behind them. Addresses whose slave is marked as powered down or clock-stopped are treated the same way. In both cases the transfer goes to a responder inside the block, so the bus never waits on a slave that cannot answer.

The block remembers which target accepted the address phase, and it updates that choice only when the bus is ready. It then multiplexes that target's ready, response and read data onto the shared bus signals. The merged ready signal goes back to all slaves as their ready input. The built-in responder gives an immediate OKAY to idle and busy transfers. It answers real transfers with a two-cycle ERROR. It is the target held during reset, so the bus reads ready in that state.

Top module: `ahb_region_decoder`

## Requirements
- R1: A byte address whose 1 KB block index (address bits above bit 9) lies in [base, base+size) of region i drives exactly bit i of `hsel` high. Regions must not overlap. The defaults are: region 0 at KB 0 with size 4, region 1 at KB 4 with size 1, region 2 at KB 16 with size 8.
- R2: An address outside every region drives `hsel` all low and routes the transfer to the built-in responder.
- R3: When `slvOff[i]` is high, an address inside region i leaves `hsel[i]` low and routes the transfer to the built-in responder.
- R4: Transfer codes on `htrans` are 00 idle, 01 busy, 10 nonsequential and 11 sequential. An idle or busy transfer accepted by the responder completes in its first data cycle with `hready` high and `hresp` low (OKAY).
- R5: A nonsequential or sequential transfer accepted by the responder returns ERROR (`hresp` high) for two cycles: first with `hready` low, then with `hready` high.
- R6: In the data phase, `hready`, `hresp` and `hrdata` equal the ready, response and read data of the slave selected in the address phase. The responder always returns read data of zero.
- R7: The data-phase target is captured only on a clock edge where `hready` is high. Address changes during wait states do not alter the data-phase mux and do not start a responder sequence.
- R8: During reset and right after it, the responder is the data-phase target, with `hready` high, `hresp` low and `hrdata` zero, even when every slave drives its ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Address-phase transfer type |
| slvOff | input | 3 | Per-slave powered-down / clock-stopped flag |
| slvReadyOut | input | 3 | Per-slave ready output |
| slvResp | input | 3 | Per-slave response, 1 = ERROR |
| slvRdata | input | 96 | Per-slave read data, slave i in bits [32i+31:32i] |
| hsel | output | 3 | One-hot slave select |
| hready | output | 1 | Merged ready, also fed back to slaves |
| hresp | output | 1 | Merged response, 1 = ERROR |
| hrdata | output | 32 | Merged read data |

## Verification
The sweep walks every 1 KB block of the low 32 KB. In each block it tries the block's first and last word, every transfer code and every combination of power-down flags. This separates mapped from unmapped blocks, shows the effect of each power flag, and separates the responder's OKAY path from its ERROR path. A stall pattern holds a slave not-ready while the address moves to an unmapped block with an active transfer. It shows that the data-phase target and the responder state stay frozen until ready returns, and that slave errors reach the merged response. A reset pattern with every slave not-ready shows that ready during reset comes from the responder alone.

// File: rtl/ahbdec_pkg.sv
package ahbdec_pkg;
  localparam int KB_SHIFT = 10;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    DS_OKAY,
    DS_ERR_FIRST,
    DS_ERR_LAST
  } defState_e;

  // strobes from control to datapath: responder outputs
  typedef struct packed {
    logic defReady;
    logic defErr;
  } ctlStrobe_t;
endpackage

// File: rtl/ahbdec_ctrl.sv
module ahbdec_ctrl
  import ahbdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hready,
  input  logic       addrIsDef,
  input  logic [1:0] htrans,
  output ctlStrobe_t ctl
);
  defState_e state;
  logic activeXfer;

  assign activeXfer = (htrans == TR_NONSEQ) || (htrans == TR_SEQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= DS_OKAY;
    end else begin
      case (state)
        DS_ERR_FIRST: state <= DS_ERR_LAST;
        default:
          if (hready && addrIsDef && activeXfer) state <= DS_ERR_FIRST;
          else                                   state <= DS_OKAY;
      endcase
    end
  end

  assign ctl.defReady = (state != DS_ERR_FIRST);
  assign ctl.defErr   = (state != DS_OKAY);

  // R5: an accepted real transfer opens the error pair
  p_err_opens_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hready && addrIsDef && activeXfer) |=> (!ctl.defReady && ctl.defErr));
  // R5: the low-ready error cycle is followed by the high-ready error cycle
  p_err_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.defReady) |=> (ctl.defReady && ctl.defErr));
  // R4: idle/busy accepted by the responder is a zero-wait OKAY
  p_idle_okay_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hready && addrIsDef && !activeXfer) |=> (ctl.defReady && !ctl.defErr));
  // R7: no sequence starts while the bus is stalled
  p_no_start_in_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!hready && !ctl.defErr) |=> ctl.defReady);
endmodule

// File: rtl/ahbdec_datapath.sv
module ahbdec_datapath
  import ahbdec_pkg::*;
#(
  parameter int          NS = 3,
  parameter int          AW = 32,
  parameter int          DW = 32,
  parameter int unsigned BASE_KB [NS] = '{0, 4, 16},
  parameter int unsigned SIZE_KB [NS] = '{4, 1, 8}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [AW-1:0]      haddr,
  input  logic [NS-1:0]      slvOff,
  input  logic [NS-1:0]      slvReadyOut,
  input  logic [NS-1:0]      slvResp,
  input  logic [NS*DW-1:0]   slvRdata,
  input  ctlStrobe_t         ctl,
  output logic [NS-1:0]      hsel,
  output logic               addrIsDef,
  output logic               hready,
  output logic               hresp,
  output logic [DW-1:0]      hrdata
);
  localparam int IW = AW - KB_SHIFT;
  localparam int EW = IW + 1;
  localparam int DEF = NS;

  logic [IW-1:0] kbIdx;
  logic [NS-1:0] inRegion;
  logic [NS:0]   dataSel;
  logic          unusedAddrLow;

  assign kbIdx         = haddr[AW-1:KB_SHIFT];
  assign unusedAddrLow = ^haddr[KB_SHIFT-1:0];

  for (genvar g = 0; g < NS; g++) begin : g_region
    localparam logic [EW-1:0] LO = EW'(BASE_KB[g]);
    localparam logic [EW-1:0] HI = EW'(BASE_KB[g] + SIZE_KB[g]);
    assign inRegion[g] = ({1'b0, kbIdx} >= LO) && ({1'b0, kbIdx} < HI);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    hsel  = '0;
    for (int i = 0; i < NS; i++) begin
      if (!found && inRegion[i]) begin
        found   = 1'b1;
        hsel[i] = !slvOff[i];
      end
    end
  end

  assign addrIsDef = ~|hsel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dataSel <= (NS+1)'(1) << DEF;
    else if (hready) dataSel <= {addrIsDef, hsel};
  end

  always_comb begin
    hready = dataSel[DEF] & ctl.defReady;
    hresp  = dataSel[DEF] & ctl.defErr;
    hrdata = '0;
    for (int i = 0; i < NS; i++) begin
      hready = hready | (dataSel[i] & slvReadyOut[i]);
      hresp  = hresp  | (dataSel[i] & slvResp[i]);
      hrdata = hrdata | (slvRdata[i*DW +: DW] & {DW{dataSel[i]}});
    end
  end

  // R1: at most one slave selected
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hsel));
  // R7: data-phase target frozen through wait states
  p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !hready |=> $stable(dataSel));
  // R2: unmapped or redirected accepted address moves the data phase to the responder
  p_def_after_unmapped_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hready && addrIsDef) |=> dataSel[DEF]);
  for (genvar g = 0; g < NS; g++) begin : g_chk
    // R6: accepted slave's ready is the bus ready in the data phase
    p_ready_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
      (hready && hsel[g]) |=> (hready == slvReadyOut[g]));
    // R3: a flagged slave is never selected
    p_off_blocked_r3: assert property (@(posedge clk) disable iff (!rstN)
      slvOff[g] |-> !hsel[g]);
  end
endmodule

// File: rtl/ahb_region_decoder.sv
module ahb_region_decoder
  import ahbdec_pkg::*;
#(
  parameter int          NS = 3,
  parameter int          AW = 32,
  parameter int          DW = 32,
  parameter int unsigned BASE_KB [NS] = '{0, 4, 16},
  parameter int unsigned SIZE_KB [NS] = '{4, 1, 8}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    haddr,
  input  logic [1:0]       htrans,
  input  logic [NS-1:0]    slvOff,
  input  logic [NS-1:0]    slvReadyOut,
  input  logic [NS-1:0]    slvResp,
  input  logic [NS*DW-1:0] slvRdata,
  output logic [NS-1:0]    hsel,
  output logic             hready,
  output logic             hresp,
  output logic [DW-1:0]    hrdata
);
  ctlStrobe_t ctl;
  logic       addrIsDef;

  ahbdec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hready    (hready),
    .addrIsDef (addrIsDef),
    .htrans    (htrans),
    .ctl       (ctl)
  );

  ahbdec_datapath #(
    .NS(NS), .AW(AW), .DW(DW), .BASE_KB(BASE_KB), .SIZE_KB(SIZE_KB)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .haddr       (haddr),
    .slvOff      (slvOff),
    .slvReadyOut (slvReadyOut),
    .slvResp     (slvResp),
    .slvRdata    (slvRdata),
    .ctl         (ctl),
    .hsel        (hsel),
    .addrIsDef   (addrIsDef),
    .hready      (hready),
    .hresp       (hresp),
    .hrdata      (hrdata)
  );
endmodule

// File: tb/sim_ahb_region_decoder.sv
module sim_ahb_region_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  slvOff = '0;
  logic [2:0]  slvReadyOut = '0;
  logic [2:0]  slvResp = '0;
  logic [95:0] slvRdata = {32'hC2C2_0002, 32'hC1C1_0001, 32'hC0C0_0000};
  logic [2:0]  hsel;
  logic        hready, hresp;
  logic [31:0] hrdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ahb_region_decoder u0 (
    .clk(clk), .rstN(rstN), .haddr(haddr), .htrans(htrans), .slvOff(slvOff),
    .slvReadyOut(slvReadyOut), .slvResp(slvResp), .slvRdata(slvRdata),
    .hsel(hsel), .hready(hready), .hresp(hresp), .hrdata(hrdata)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // independent region table: KB [0,4) -> 0, [4,5) -> 1, [16,24) -> 2
  function automatic int mapRegion(logic [31:0] a);
    int kb = int'(a >> 10);
    if (kb < 4) return 0;
    if (kb < 5) return 1;
    if (kb >= 16 && kb < 24) return 2;
    return -1;
  endfunction

  task automatic doXfer(logic [31:0] a, logic [1:0] tr, logic [2:0] off);
    int r = mapRegion(a);
    int tgt = (r >= 0 && !off[r]) ? r : -1;
    @(negedge clk);
    haddr = a; htrans = tr; slvOff = off;
    #1;
    check(r < 0 ? "R2 hsel" : (tgt < 0 ? "R3 hsel" : "R1 hsel"),
          64'(hsel), tgt < 0 ? 64'd0 : 64'(3'b001 << tgt));
    @(negedge clk);
    haddr = '0; htrans = 2'b00; slvOff = '0;
    #1;
    if (tgt < 0 && tr[1]) begin
      check("R5 err first", {hready, hresp}, 64'b01);
      @(negedge clk); #1;
      check("R5 err last", {hready, hresp}, 64'b11);
      @(negedge clk); #1;
      check("R6 after err", {hready, hresp}, 64'b10);
    end else if (tgt < 0) begin
      check("R4 idle okay", {hready, hresp, hrdata}, {2'b10, 32'h0});
    end else begin
      check("R6 slave data", {hready, hresp, hrdata},
            {2'b10, slvRdata[tgt*32 +: 32]});
    end
  endtask

  initial begin
    // R8: reset with all slaves not ready
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R8 in reset", {hready, hresp, hrdata}, {2'b10, 32'h0});
    rstN = 1'b1;
    #1;
    check("R8 after reset", {hready, hresp}, 64'b10);
    slvReadyOut = 3'b111;

    // sweep: every KB block, first/last word, all codes, all power flags
    for (int kb = 0; kb < 32; kb++)
      for (int w = 0; w < 2; w++)
        for (int tr = 0; tr < 4; tr++)
          for (int off = 0; off < 8; off++)
            doXfer(32'(kb * 1024 + w * 1020), 2'(tr), 3'(off));

    // R7: stall on slave 1 while address moves to an unmapped block
    slvReadyOut[1] = 1'b0; slvResp[1] = 1'b1;
    @(negedge clk); haddr = 32'h1000; htrans = 2'b10;
    @(negedge clk); haddr = 32'h7000; htrans = 2'b10; #1;
    check("R6 stalled slave", {hready, hresp, hrdata}, {2'b01, 32'hC1C1_0001});
    @(negedge clk); #1;
    check("R7 select held", {hready, hrdata}, {1'b0, 32'hC1C1_0001});
    @(negedge clk); #1;
    check("R7 no responder start", {hready, hresp}, 64'b01);
    slvReadyOut[1] = 1'b1; #1;
    check("R7 release", 64'(hready), 64'd1);
    @(negedge clk); haddr = '0; htrans = 2'b00; slvResp[1] = 1'b0; #1;
    check("R7 err after stall", {hready, hresp}, 64'b01);
    @(negedge clk); #1;
    check("R5 err tail after stall", {hready, hresp}, 64'b11);
    @(negedge clk); #1;
    check("R6 back to okay", {hready, hresp}, 64'b10);

    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R6 watchdog: actual=hung expected=done");
    finishRun();
  end
endmodule